// File: doc/BRIEF.md
# Power-Good Reset Supervisor

This block turns four threshold-crossing flags on a regulated rail into a delayed, active-low reset for a downstream processor. Two of the flags describe the lower edge of the acceptable voltage window and two describe the upper edge. A set/clear hysteresis cell for each edge turns them into a single "inside the window" state. That state must hold for a short deglitch interval before an internal power-good is raised. Power-good must then hold for a long qualification interval before the reset is released.

An external inhibit input holds the reset asserted while it is high, whatever the rail is doing, and keeps the long counter at zero. Its falling edge therefore starts the long interval afresh, provided the rail is in the window. The regulator enable gates everything: while it is low the reset stays asserted, and its rising edge begins a new qualification. The output models an open-drain pin as a logic level together with a pull-down enable. All intervals are counted in clock ticks set by parameters.

Top module: `pgs_supervisor`

## Requirements
- R1: Lower edge. `lo_rise_above`=1 means the rail is above the upper hysteresis point (92 % of nominal), and `lo_fall_above`=1 means it is above the lower point (88 %). The lower bound becomes satisfied at the clock edge after `lo_rise_above` is 1. It stays satisfied while `lo_fall_above` is 1, and it is lost at the edge after `lo_fall_above` is 0. A rail that only sits between the two points never becomes satisfied.
- R2: Upper edge. `hi_rise_above`=1 means the rail is above 108 %, and `hi_fall_above`=1 means it is above 105 %. The over-voltage trip sets at the edge after `hi_rise_above` is 1. It stays set while `hi_fall_above` is 1, and it clears at the edge after `hi_fall_above` is 0. The rail is in the window only while the lower bound is satisfied, the trip is clear and `enable` is 1.
- R3: Internal power-good rises only after the rail has been in the window for `DEGLITCH_TICKS` consecutive clock edges. Any gap restarts this count from zero.
- R4: After power-good rises, `por_level` goes to 1 once `DELAY_TICKS` further edges have passed. Flags that move into the window in one cycle thus release the reset exactly 1+`DEGLITCH_TICKS`+`DELAY_TICKS` edges later.
- R5: While `inhibit` is 1, `por_level` is 0 in the same cycle, regardless of power-good.
- R6: While `inhibit` is 1, the long counter is held at zero. After `inhibit` falls with the rail qualified, `por_level` rises exactly `DELAY_TICKS` edges later. If the rail is outside the window when `inhibit` falls, the reset stays asserted until a full qualification completes.
- R7: When the rail leaves the window, `por_level` drops as soon as the window state changes, one edge after the flag change. Both counters restart from zero.
- R8: `enable`=0 forces `por_level` to 0 in the same cycle. When `enable` returns to 1 with the rail in the window, `por_level` rises after `DEGLITCH_TICKS`+`DELAY_TICKS` edges.
- R9: After the synchronous reset `rst`, `por_level` is 0 and `por_pull` is 1.
- R10: `por_pull` is always the inverse of `por_level`: the pin is pulled low exactly when the reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| enable | input | 1 | Regulator enable; low means shutdown |
| lo_rise_above | input | 1 | Rail above the lower-edge rising point (92 %) |
| lo_fall_above | input | 1 | Rail above the lower-edge falling point (88 %) |
| hi_rise_above | input | 1 | Rail above the upper-edge rising point (108 %) |
| hi_fall_above | input | 1 | Rail above the upper-edge falling point (105 %) |
| inhibit | input | 1 | External reset-inhibit; high holds reset asserted |
| por_level | output | 1 | Reset level: 1 released, 0 asserted |
| por_pull | output | 1 | Open-drain pull-down enable: 1 drives the pin low |

## Verification
The bench builds the block with `DEGLITCH_TICKS`=4, `DELAY_TICKS`=10 and a 4-bit long counter. At that size a full qualification takes fifteen edges, so every cycle of it can be checked. The bench sweeps a window drop-out across each edge of the deglitch and the long interval, and checks that the release timing after re-entry is exact each time. The short counts also make it cheap to visit each hysteresis band from both sides, and to exercise the inhibit release in three states: qualified, mid-qualification and outside the window.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    // One window edge: the rail against its rising and its falling point.
    typedef struct packed {
        logic rise_above;
        logic fall_above;
    } bound_flags_t;

    localparam int NUM_BOUNDS = 2;
    localparam int BOUND_LO   = 0;
    localparam int BOUND_HI   = 1;

    // Bits needed to hold the values 0..limit.
    function automatic int cnt_width(input int unsigned limit);
        int w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/pgs_hyst.sv
module pgs_hyst
    import pgs_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  bound_flags_t flags,
    output logic         state
);
    // Sets above the rising point; holds until the rail drops below the falling point.
    always_ff @(posedge clk) begin
        if (rst)
            state <= 1'b0;
        else if (flags.rise_above)
            state <= 1'b1;
        else if (!flags.fall_above)
            state <= 1'b0;
    end
endmodule

// File: rtl/pgs_qual_counter.sv
module pgs_qual_counter #(
    parameter int unsigned LIMIT = 4,
    parameter int          CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    // Counts edges while run holds; saturates at LIMIT; a drop of run clears it.
    always_ff @(posedge clk) begin
        if (rst || !run)
            count <= '0;
        else if (count != LIM)
            count <= count + 1'b1;
    end

    assign done = run && (count == LIM);
endmodule

// File: rtl/pgs_supervisor.sv
module pgs_supervisor
    import pgs_pkg::*;
#(
    parameter int unsigned DEGLITCH_TICKS = 12800,
    parameter int unsigned DELAY_TICKS    = 43200000,
    parameter int          DELAY_W        = 26
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic lo_rise_above,
    input  logic lo_fall_above,
    input  logic hi_rise_above,
    input  logic hi_fall_above,
    input  logic inhibit,
    output logic por_level,
    output logic por_pull
);
    localparam int DG_W = cnt_width(DEGLITCH_TICKS);

    bound_flags_t [NUM_BOUNDS-1:0] bnd_flags;
    logic         [NUM_BOUNDS-1:0] bnd_state;

    assign bnd_flags[BOUND_LO] = '{rise_above: lo_rise_above, fall_above: lo_fall_above};
    assign bnd_flags[BOUND_HI] = '{rise_above: hi_rise_above, fall_above: hi_fall_above};

    for (genvar b = 0; b < NUM_BOUNDS; b++) begin : g_bound
        pgs_hyst u_hyst (
            .clk   (clk),
            .rst   (rst),
            .flags (bnd_flags[b]),
            .state (bnd_state[b])
        );
    end

    logic lo_ok, hi_trip, in_window;
    assign lo_ok     = bnd_state[BOUND_LO];
    assign hi_trip   = bnd_state[BOUND_HI];
    assign in_window = enable && lo_ok && !hi_trip;

    logic            pwr_good;
    logic [DG_W-1:0] dg_count;

    pgs_qual_counter #(.LIMIT(DEGLITCH_TICKS), .CNT_W(DG_W)) u_deglitch (
        .clk   (clk),
        .rst   (rst),
        .run   (in_window),
        .done  (pwr_good),
        .count (dg_count)
    );

    logic               dly_run, dly_done;
    logic [DELAY_W-1:0] dly_count;
    assign dly_run = pwr_good && !inhibit;

    pgs_qual_counter #(.LIMIT(DELAY_TICKS), .CNT_W(DELAY_W)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .run   (dly_run),
        .done  (dly_done),
        .count (dly_count)
    );

    assign por_level = dly_done;
    assign por_pull  = !dly_done;
endmodule

// File: rtl/pgs_supervisor_chk.sv
module pgs_supervisor_chk #(
    parameter int DG_W    = 3,
    parameter int DELAY_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               inhibit,
    input logic               lo_fall_above,
    input logic               hi_fall_above,
    input logic               lo_ok,
    input logic               hi_trip,
    input logic               in_window,
    input logic               pwr_good,
    input logic [DG_W-1:0]    dg_count,
    input logic [DELAY_W-1:0] dly_count,
    input logic               por_level,
    input logic               por_pull
);
    p_lo_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (lo_ok && lo_fall_above) |=> lo_ok);

    p_hi_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (hi_trip && hi_fall_above) |=> hi_trip);

    p_deglitch_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !in_window |=> (dg_count == '0));

    p_good_needs_window_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good) |-> $past(in_window));

    p_release_after_good_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(por_level) |-> ($past(pwr_good) && !$past(inhibit)));

    p_inhibit_low_r5: assert property (@(posedge clk) disable iff (rst)
        inhibit |-> !por_level);

    p_inhibit_clears_r6: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> (dly_count == '0));

    p_window_low_r7: assert property (@(posedge clk) disable iff (rst)
        !in_window |-> !por_level);

    p_pull_inverse_r10: assert property (@(posedge clk) disable iff (rst)
        por_pull != por_level);
endmodule

bind pgs_supervisor pgs_supervisor_chk #(.DG_W(DG_W), .DELAY_W(DELAY_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .inhibit       (inhibit),
    .lo_fall_above (lo_fall_above),
    .hi_fall_above (hi_fall_above),
    .lo_ok         (lo_ok),
    .hi_trip       (hi_trip),
    .in_window     (in_window),
    .pwr_good      (pwr_good),
    .dg_count      (dg_count),
    .dly_count     (dly_count),
    .por_level     (por_level),
    .por_pull      (por_pull)
);

// File: tb/test_pgs_supervisor.sv
`timescale 1ns/1ps
module test_pgs_supervisor;
    localparam int DG    = 4;
    localparam int DLY   = 10;
    localparam int TOTAL = 1 + DG + DLY;

    logic clk = 1'b0;
    logic rst, enable, lo_rise, lo_fall, hi_rise, hi_fall, inhibit;
    logic por_level, por_pull;
    int   tests = 0;
    int   fails = 0;
    bit   done  = 1'b0;

    always #2.5 clk = ~clk;

    pgs_supervisor #(.DEGLITCH_TICKS(DG), .DELAY_TICKS(DLY), .DELAY_W(4)) i_pgs_supervisor (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .lo_rise_above (lo_rise),
        .lo_fall_above (lo_fall),
        .hi_rise_above (hi_rise),
        .hi_fall_above (hi_fall),
        .inhibit       (inhibit),
        .por_level     (por_level),
        .por_pull      (por_pull)
    );

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_por(input logic exp, input string tag);
        tests++;
        if (por_level !== exp || por_pull !== ~exp) begin
            fails++;
            $display("FAIL %s: por_level=%b por_pull=%b, expected level %b pull %b",
                     tag, por_level, por_pull, exp, ~exp);
        end
    endtask

    // Checks every edge: released from edge lat onward.
    task automatic measure(input int lat, input string tag);
        for (int m = 1; m <= lat + 2; m++) begin
            ticks(1);
            expect_por(m >= lat, tag);
        end
    endtask

    task automatic set_in();
        lo_rise = 1'b1; lo_fall = 1'b1; hi_rise = 1'b0; hi_fall = 1'b0;
    endtask

    task automatic set_low_out();
        lo_rise = 1'b0; lo_fall = 1'b0;
    endtask

    initial begin
        rst = 1'b1; enable = 1'b1; inhibit = 1'b0;
        lo_rise = 1'b0; lo_fall = 1'b0; hi_rise = 1'b0; hi_fall = 1'b0;
        ticks(3);
        expect_por(1'b0, "R9 reset state");
        rst = 1'b0;
        ticks(2);
        expect_por(1'b0, "R10 out of window after reset");

        // R4: full qualification from below the window
        set_in();
        measure(TOTAL, "R4 full delay");

        // R1: lower hysteresis band, approached from above and from below
        lo_rise = 1'b0;
        ticks(TOTAL + 2);
        expect_por(1'b1, "R1 hold inside lower band");
        lo_fall = 1'b0;
        ticks(1);
        expect_por(1'b0, "R7 drop below falling point");
        lo_fall = 1'b1;
        ticks(TOTAL + 3);
        expect_por(1'b0, "R1 band from below does not qualify");
        lo_rise = 1'b1;
        measure(TOTAL, "R1 rise above rising point");

        // R2: upper hysteresis band
        hi_rise = 1'b1; hi_fall = 1'b1;
        ticks(1);
        expect_por(1'b0, "R2 over-voltage trip");
        hi_rise = 1'b0;
        ticks(TOTAL + 3);
        expect_por(1'b0, "R2 trip held inside upper band");
        hi_fall = 1'b0;
        measure(TOTAL, "R2 trip cleared");

        // R3/R7: drop-out at every edge of a qualification
        for (int j = 1; j <= TOTAL + 1; j++) begin
            set_low_out();
            ticks(2);
            set_in();
            ticks(j);
            set_low_out();
            ticks(1);
            expect_por(1'b0, "R7 drop-out sweep");
            set_in();
            measure(TOTAL, "R3 requalify after drop-out");
        end

        // R5/R6: inhibit while qualified
        inhibit = 1'b1;
        #1;
        expect_por(1'b0, "R5 inhibit same cycle");
        ticks(TOTAL + 2);
        expect_por(1'b0, "R5 inhibit held");
        inhibit = 1'b0;
        measure(DLY, "R6 release restarts delay");

        // R6: inhibit held through deglitch, released after power-good
        set_low_out();
        ticks(2);
        inhibit = 1'b1;
        set_in();
        ticks(DG + 3);
        expect_por(1'b0, "R5 inhibit during qualification");
        inhibit = 1'b0;
        measure(DLY, "R6 counter held cleared");

        // R6: inhibit falls while outside the window
        inhibit = 1'b1;
        ticks(1);
        set_low_out();
        ticks(2);
        inhibit = 1'b0;
        ticks(TOTAL + 2);
        expect_por(1'b0, "R6 release outside window");
        set_in();
        measure(TOTAL, "R6 full qualification after release");

        // R8: enable gating
        enable = 1'b0;
        #1;
        expect_por(1'b0, "R8 enable low same cycle");
        ticks(2);
        expect_por(1'b0, "R8 enable low held");
        enable = 1'b1;
        measure(DG + DLY, "R8 enable rise restarts");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung, expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule